// File: doc/BRIEF.md
# Page-Buffered Nonvolatile Write Controller

This block models the write path of a byte-wide parallel nonvolatile memory that gathers host byte loads into a page buffer before committing them. The host drives active-low chip-enable, output-enable and write-enable strobes together with an address and a data bus. Every input is sampled on a fast system clock. A qualified low pulse on the strobes loads one byte into the page buffer and marks that byte valid.

Each accepted load reopens a load window. When the window runs out with no further load, the block raises `busy` and starts a programming period of fixed length. During that period the block walks the buffer and issues one array write for each valid byte, in ascending offset order. Bytes that were never loaded receive no write. While `busy` is high, new loads are dropped. When the period ends, the buffer's valid marks are cleared.

All times are parameters counted in clock cycles. A system integrator sets them from the clock frequency, and a bench can shrink them.

Top module: `pgwr_ctrl`

## Requirements
- R1: The upper address bits [14:6] name the page and the lower bits [5:0] name the byte within it. Every array write carries the page of the first load concatenated with the byte offset, so all writes of one period share the same upper bits.
- R2: A load is recognised only while `ce_n`=0, `we_n`=0 and `oe_n`=1 all hold together. A low pulse with `oe_n`=0, or `we_n` low while `ce_n` is high, loads nothing.
- R3: The address is taken in the first sampled cycle in which the load condition holds, which is the later of the two enable falls. The data is taken from the last sampled cycle before the condition ends, which is the earlier of the two rises. Address changes later in the pulse are ignored.
- R4: A qualifying low pulse that lasts fewer than MIN_LOW_CYC sampled cycles is discarded. A pulse of exactly MIN_LOW_CYC cycles is accepted.
- R5: A load accepted within LOAD_WIN_CYC cycles of the previous accepted load joins the same period. If no load is accepted for that long, `busy` rises. When the strobe rise is sampled at clock edge N, `busy` is first high after edge N+LOAD_WIN_CYC+2.
- R6: Bytes may be loaded in any offset order. Reloading an offset before programming keeps only the newest value.
- R7: Exactly one array write is issued per loaded byte, in strictly ascending offset order. Offsets that were not loaded receive no write.
- R8: `busy` stays high for exactly PROG_CYC consecutive cycles. `arr_we` is asserted only while `busy` is high.
- R9: A load whose page differs from the page of the first load in the period is ignored.
- R10: Loads that arrive while `busy` is high are ignored. They start no later period and produce no write.
- R11: In and right after reset, `busy` and `arr_we` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock on which all strobes are sampled |
| rst_n | input | 1 | Active-low asynchronous reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low; low blocks a load |
| we_n | input | 1 | Write enable, active low |
| addr | input | 15 | Host byte address |
| din | input | 8 | Host write data |
| busy | output | 1 | High for the duration of the programming period |
| arr_we | output | 1 | Backing array write strobe, one cycle per byte |
| arr_addr | output | 15 | Backing array write address |
| arr_data | output | 8 | Backing array write data |

## Verification
The bench sends pulses one cycle shorter than the glitch limit and exactly at it. A design with an off-by-one filter would either start a period on noise or reject a legal load. It moves the address after the enables meet and changes the data in the final low cycle. A design that took either value on the wrong edge would write the wrong location or stale data. It reloads one offset, mixes pages, loads during `busy`, and places a second load just inside the window. A wrong design would then write twice, write a foreign page, run an extra period, or split one burst into two periods. A reverse-order sweep over all 64 offsets, with values computed arithmetically, confirms that each byte lands exactly once.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_LOAD = 2'd1,
        PH_PROG = 2'd2
    } phase_e;

    function automatic int unsigned cnt_width(input int unsigned limit);
        return (limit < 2) ? 1 : $clog2(limit + 1);
    endfunction
endpackage

// File: rtl/pgwr_strobe.sv
module pgwr_strobe #(
    parameter int ADDR_W      = 15,
    parameter int DATA_W      = 8,
    parameter int MIN_LOW_CYC = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              ld_vld,
    output logic [ADDR_W-1:0] ld_addr,
    output logic [DATA_W-1:0] ld_data
);
    import pgwr_pkg::*;

    localparam int CNT_W = cnt_width(MIN_LOW_CYC);

    typedef struct packed {
        logic              ce_n;
        logic              oe_n;
        logic              we_n;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] din;
        logic              prev_low;
        logic [CNT_W-1:0]  cnt;
        logic [ADDR_W-1:0] cap_addr;
        logic [DATA_W-1:0] cap_data;
        logic              ld_vld;
    } st_t;

    st_t st_q, st_d;
    logic low_now;

    always_comb begin
        st_d        = st_q;
        st_d.ce_n   = ce_n;
        st_d.oe_n   = oe_n;
        st_d.we_n   = we_n;
        st_d.addr   = addr;
        st_d.din    = din;
        st_d.ld_vld = 1'b0;
        low_now     = !st_q.ce_n && !st_q.we_n && st_q.oe_n;
        st_d.prev_low = low_now;
        if (low_now) begin
            st_d.cap_data = st_q.din;
            if (!st_q.prev_low) begin
                st_d.cap_addr = st_q.addr;
                st_d.cnt      = CNT_W'(1);
            end else if (st_q.cnt < CNT_W'(MIN_LOW_CYC)) begin
                st_d.cnt = st_q.cnt + CNT_W'(1);
            end
        end else begin
            if (st_q.prev_low && (st_q.cnt >= CNT_W'(MIN_LOW_CYC))) begin
                st_d.ld_vld = 1'b1;
            end
            st_d.cnt = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q      <= '0;
            st_q.ce_n <= 1'b1;
            st_q.oe_n <= 1'b1;
            st_q.we_n <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign ld_vld  = st_q.ld_vld;
    assign ld_addr = st_q.cap_addr;
    assign ld_data = st_q.cap_data;
endmodule

// File: rtl/pgwr_pagebuf.sv
module pgwr_pagebuf #(
    parameter int DATA_W = 8,
    parameter int OFFS_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [OFFS_W-1:0] wr_offs,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              clr,
    input  logic [OFFS_W-1:0] rd_offs,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << OFFS_W;

    typedef struct packed {
        logic [DEPTH-1:0][DATA_W-1:0] data;
        logic [DEPTH-1:0]             valid;
    } st_t;

    st_t st_q, st_d;
    logic [DEPTH-1:0] hit;

    for (genvar g = 0; g < DEPTH; g++) begin : g_hit
        assign hit[g] = wr && (wr_offs == OFFS_W'(g));
    end

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < DEPTH; i++) begin
            if (clr) begin
                st_d.valid[i] = 1'b0;
            end else if (hit[i]) begin
                st_d.valid[i] = 1'b1;
                st_d.data[i]  = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign rd_data  = st_q.data[rd_offs];
    assign rd_valid = st_q.valid[rd_offs];
endmodule

// File: rtl/pgwr_seq.sv
module pgwr_seq #(
    parameter int ADDR_W       = 15,
    parameter int OFFS_W       = 6,
    parameter int LOAD_WIN_CYC = 75000,
    parameter int PROG_CYC     = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_vld,
    input  logic [ADDR_W-1:0] ld_addr,
    input  logic              rd_valid,
    output logic              buf_wr,
    output logic [OFFS_W-1:0] buf_offs,
    output logic              buf_clr,
    output logic [OFFS_W-1:0] scan_offs,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr
);
    import pgwr_pkg::*;

    localparam int PAGE_W = ADDR_W - OFFS_W;
    localparam int WIN_W  = cnt_width(LOAD_WIN_CYC);
    localparam int PROG_W = cnt_width(PROG_CYC);

    typedef struct packed {
        phase_e            phase;
        logic [PAGE_W-1:0] page;
        logic [WIN_W-1:0]  win;
        logic [PROG_W-1:0] prog;
        logic [OFFS_W-1:0] scan;
        logic              scan_done;
    } st_t;

    st_t st_q, st_d;
    logic [PAGE_W-1:0] ld_page;

    assign ld_page  = ld_addr[ADDR_W-1:OFFS_W];
    assign buf_offs = ld_addr[OFFS_W-1:0];

    always_comb begin
        st_d    = st_q;
        buf_wr  = 1'b0;
        buf_clr = 1'b0;
        unique case (st_q.phase)
            PH_IDLE: begin
                if (ld_vld) begin
                    buf_wr     = 1'b1;
                    st_d.page  = ld_page;
                    st_d.win   = '0;
                    st_d.phase = PH_LOAD;
                end
            end
            PH_LOAD: begin
                if (ld_vld && (ld_page == st_q.page)) begin
                    buf_wr   = 1'b1;
                    st_d.win = '0;
                end else if (st_q.win == WIN_W'(LOAD_WIN_CYC - 1)) begin
                    st_d.phase     = PH_PROG;
                    st_d.prog      = '0;
                    st_d.scan      = '0;
                    st_d.scan_done = 1'b0;
                end else begin
                    st_d.win = st_q.win + WIN_W'(1);
                end
            end
            PH_PROG: begin
                if (!st_q.scan_done) begin
                    if (st_q.scan == {OFFS_W{1'b1}}) st_d.scan_done = 1'b1;
                    else                             st_d.scan = st_q.scan + OFFS_W'(1);
                end
                if (st_q.prog == PROG_W'(PROG_CYC - 1)) begin
                    buf_clr    = 1'b1;
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.prog = st_q.prog + PROG_W'(1);
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign scan_offs = st_q.scan;
    assign busy      = (st_q.phase == PH_PROG);
    assign arr_we    = busy && !st_q.scan_done && rd_valid;
    assign arr_addr  = {st_q.page, st_q.scan};
endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl #(
    parameter int ADDR_W       = 15,
    parameter int DATA_W       = 8,
    parameter int OFFS_W       = 6,
    parameter int MIN_LOW_CYC  = 8,
    parameter int LOAD_WIN_CYC = 75000,
    parameter int PROG_CYC     = 5000000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ce_n,
    input  logic              oe_n,
    input  logic              we_n,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] din,
    output logic              busy,
    output logic              arr_we,
    output logic [ADDR_W-1:0] arr_addr,
    output logic [DATA_W-1:0] arr_data
);
    localparam int DEPTH = 1 << OFFS_W;

    initial begin
        if (PROG_CYC < DEPTH + 1) $error("PROG_CYC must exceed the page depth");
    end

    logic              ld_vld;
    logic [ADDR_W-1:0] ld_addr;
    logic [DATA_W-1:0] ld_data;
    logic              buf_wr;
    logic [OFFS_W-1:0] buf_offs;
    logic              buf_clr;
    logic [OFFS_W-1:0] scan_offs;
    logic              rd_valid;

    pgwr_strobe #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .MIN_LOW_CYC(MIN_LOW_CYC)
    ) u_strobe (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .ld_data(ld_data)
    );

    pgwr_pagebuf #(
        .DATA_W(DATA_W), .OFFS_W(OFFS_W)
    ) u_buf (
        .clk(clk), .rst_n(rst_n),
        .wr(buf_wr), .wr_offs(buf_offs), .wr_data(ld_data),
        .clr(buf_clr), .rd_offs(scan_offs),
        .rd_data(arr_data), .rd_valid(rd_valid)
    );

    pgwr_seq #(
        .ADDR_W(ADDR_W), .OFFS_W(OFFS_W),
        .LOAD_WIN_CYC(LOAD_WIN_CYC), .PROG_CYC(PROG_CYC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .ld_vld(ld_vld), .ld_addr(ld_addr), .rd_valid(rd_valid),
        .buf_wr(buf_wr), .buf_offs(buf_offs), .buf_clr(buf_clr),
        .scan_offs(scan_offs), .busy(busy),
        .arr_we(arr_we), .arr_addr(arr_addr)
    );
endmodule

// File: rtl/pgwr_chk.sv
module pgwr_chk #(
    parameter int ADDR_W   = 15,
    parameter int OFFS_W   = 6,
    parameter int PROG_CYC = 5000000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              busy,
    input logic              arr_we,
    input logic [ADDR_W-1:0] arr_addr,
    input logic              buf_wr
);
    logic [31:0] bcnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    bcnt_q <= '0;
        else if (busy) bcnt_q <= bcnt_q + 32'd1;
        else           bcnt_q <= '0;
    end

    AST_WE_NEEDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        arr_we |-> busy); // R8

    AST_BUSY_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy) |-> (bcnt_q == 32'(PROG_CYC))); // R8

    AST_SAME_PAGE: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[ADDR_W-1:OFFS_W] == $past(arr_addr[ADDR_W-1:OFFS_W]))); // R1

    AST_OFFS_ASCEND: assert property (@(posedge clk) disable iff (!rst_n)
        (arr_we && $past(arr_we)) |->
            (arr_addr[OFFS_W-1:0] > $past(arr_addr[OFFS_W-1:0]))); // R7

    AST_NO_LOAD_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> !buf_wr); // R10

    AST_RESET_QUIET: assert property (@(posedge clk)
        !rst_n |=> (!busy && !arr_we)); // R11
endmodule

bind pgwr_ctrl pgwr_chk #(
    .ADDR_W(ADDR_W), .OFFS_W(OFFS_W), .PROG_CYC(PROG_CYC)
) u_chk (
    .clk(clk), .rst_n(rst_n), .busy(busy), .arr_we(arr_we),
    .arr_addr(arr_addr), .buf_wr(buf_wr)
);

// File: tb/sim_pgwr_ctrl.sv
module sim_pgwr_ctrl;
    localparam int MINL = 3;
    localparam int WIN  = 40;
    localparam int PROG = 100;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ce_n = 1'b1, oe_n = 1'b1, we_n = 1'b1;
    logic [14:0] addr = '0;
    logic [7:0]  din = '0;
    logic        busy, arr_we;
    logic [14:0] arr_addr;
    logic [7:0]  arr_data;

    always #4 clk = ~clk;

    pgwr_ctrl #(.MIN_LOW_CYC(MINL), .LOAD_WIN_CYC(WIN), .PROG_CYC(PROG)) u0 (
        .clk(clk), .rst_n(rst_n), .ce_n(ce_n), .oe_n(oe_n), .we_n(we_n),
        .addr(addr), .din(din), .busy(busy), .arr_we(arr_we),
        .arr_addr(arr_addr), .arr_data(arr_data)
    );

    int checks = 0, errors = 0;
    int wcnt = 0, blen = 0, last_blen = 0, nbusy = 0;
    logic [7:0] mem_m [int];

    always @(negedge clk) begin
        if (rst_n) begin
            if (arr_we) begin
                mem_m[int'(arr_addr)] = arr_data;
                wcnt++;
            end
            if (busy) blen++;
            else if (blen != 0) begin
                last_blen = blen;
                blen = 0;
                nbusy++;
            end
        end
    end

    function automatic logic [14:0] mk(input int page, input int off);
        return {9'(page), 6'(off)};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic chk_mem(input string tag, input logic [14:0] a, input int exp);
        int act;
        act = mem_m.exists(int'(a)) ? int'(mem_m[int'(a)]) : -1;
        chk(tag, act, exp);
    endtask

    task automatic pulse(input logic [14:0] a, input logic [7:0] d, input int len);
        @(negedge clk);
        addr = a; din = d; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b1;
        repeat (len) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic wait_done();
        int t = 0;
        while (!busy && t < 5000) begin @(negedge clk); t++; end
        while (busy && t < 5000) begin @(negedge clk); t++; end
        repeat (3) @(negedge clk);
        if (t >= 5000) chk("wait_done timeout", 1, 0);
    endtask

    initial begin
        #(8 * 150000);
        errors++;
        $display("FAIL watchdog actual 1 expected 0");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        int w0, b0;
        repeat (3) @(negedge clk);
        chk("R11 busy in reset", int'(busy), 0);
        chk("R11 arr_we in reset", int'(arr_we), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        chk("R11 busy after reset", int'(busy), 0);

        // R1 R6 R7 R5 R8: three bytes out of order, exact start timing
        w0 = wcnt;
        pulse(mk(18, 5), 8'h11, 3);
        pulse(mk(18, 0), 8'h22, 3);
        @(negedge clk);
        addr = mk(18, 63); din = 8'h33; ce_n = 1'b0; we_n = 1'b0;
        repeat (3) @(negedge clk);
        we_n = 1'b1; ce_n = 1'b1;
        @(posedge clk);
        repeat (WIN + 1) @(posedge clk);
        @(negedge clk);
        chk("R5 busy still low at window edge", int'(busy), 0);
        @(posedge clk);
        @(negedge clk);
        chk("R5 busy high after window", int'(busy), 1);
        wait_done();
        chk("R8 busy length", last_blen, PROG);
        chk("R7 write count", wcnt - w0, 3);
        chk_mem("R1 byte at offset 5", mk(18, 5), 8'h11);
        chk_mem("R6 byte at offset 0", mk(18, 0), 8'h22);
        chk_mem("R6 byte at offset 63", mk(18, 63), 8'h33);
        chk_mem("R7 unloaded offset 1", mk(18, 1), -1);

        // R6 reload keeps newest
        w0 = wcnt;
        pulse(mk(32, 9), 8'h44, 3);
        pulse(mk(32, 9), 8'h55, 3);
        wait_done();
        chk("R6 single write after reload", wcnt - w0, 1);
        chk_mem("R6 newest value", mk(32, 9), 8'h55);

        // R9 foreign page ignored
        w0 = wcnt;
        pulse(mk(3, 1), 8'h66, 3);
        pulse(mk(4, 2), 8'h77, 3);
        wait_done();
        chk("R9 write count", wcnt - w0, 1);
        chk_mem("R9 first page byte", mk(3, 1), 8'h66);
        chk_mem("R9 foreign page byte", mk(4, 2), -1);

        // R4 glitch filter
        w0 = wcnt; b0 = nbusy;
        pulse(mk(5, 7), 8'h88, MINL - 1);
        repeat (WIN + 20) @(negedge clk);
        chk("R4 short pulse no period", nbusy - b0, 0);
        chk("R4 short pulse no write", int'(busy), 0);
        pulse(mk(5, 8), 8'h99, MINL);
        wait_done();
        chk("R4 minimum pulse writes", wcnt - w0, 1);
        chk_mem("R4 minimum pulse value", mk(5, 8), 8'h99);
        chk_mem("R4 short pulse byte", mk(5, 7), -1);

        // R2 blocked by oe low or ce high
        w0 = wcnt; b0 = nbusy;
        @(negedge clk);
        addr = mk(6, 1); din = 8'hAA; ce_n = 1'b0; we_n = 1'b0; oe_n = 1'b0;
        repeat (5) @(negedge clk);
        ce_n = 1'b1; we_n = 1'b1; oe_n = 1'b1;
        repeat (3) @(negedge clk);
        addr = mk(6, 2); we_n = 1'b0;
        repeat (5) @(negedge clk);
        we_n = 1'b1;
        repeat (WIN + 20) @(negedge clk);
        chk("R2 blocked strobes no period", nbusy - b0, 0);
        chk("R2 blocked strobes no write", wcnt - w0, 0);

        // R3 address on later fall, data on earlier rise
        w0 = wcnt;
        @(negedge clk);
        addr = mk(7, 50); din = 8'h01; we_n = 1'b0; ce_n = 1'b1;
        @(negedge clk);
        addr = mk(7, 20); din = 8'h02; ce_n = 1'b0;
        repeat (2) @(negedge clk);
        addr = mk(7, 30); din = 8'hC3;
        @(negedge clk);
        ce_n = 1'b1;
        @(negedge clk);
        addr = mk(7, 40); din = 8'h04;
        @(negedge clk);
        we_n = 1'b1;
        wait_done();
        chk("R3 one write", wcnt - w0, 1);
        chk_mem("R3 address at later fall, data at earlier rise", mk(7, 20), 8'hC3);
        chk_mem("R3 mid-pulse address unused", mk(7, 30), -1);

        // R10 load during busy ignored
        w0 = wcnt; b0 = nbusy;
        pulse(mk(8, 0), 8'hA1, 3);
        repeat (WIN + 12) @(negedge clk);
        chk("R10 busy during late load", int'(busy), 1);
        pulse(mk(8, 1), 8'hA2, 3);
        wait_done();
        repeat (WIN + 20) @(negedge clk);
        chk("R10 one period", nbusy - b0, 1);
        chk("R10 one write", wcnt - w0, 1);
        chk_mem("R10 dropped byte", mk(8, 1), -1);

        // R5 second load inside window merges
        w0 = wcnt; b0 = nbusy;
        pulse(mk(9, 3), 8'hB1, 3);
        repeat (WIN - 12) @(negedge clk);
        pulse(mk(9, 4), 8'hB2, 3);
        wait_done();
        chk("R5 merged into one period", nbusy - b0, 1);
        chk("R5 merged writes", wcnt - w0, 2);
        chk_mem("R5 late byte", mk(9, 4), 8'hB2);

        // R7 R1 full page sweep in reverse order
        w0 = wcnt;
        for (int off = 63; off >= 0; off--) begin
            pulse(mk(511, off), 8'((off * 3 + 7) & 255), MINL);
        end
        wait_done();
        chk("R7 full page write count", wcnt - w0, 64);
        for (int off = 0; off < 64; off++) begin
            chk_mem("R1 sweep byte", mk(511, off), (off * 3 + 7) & 255);
        end
        chk("R8 busy length on full page", last_blen, PROG);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule